// File: doc/BRIEF.md
# Compare/Capture Timer with PWM Output

This block is a free-running up-counter with a register port for software. The counter can be started and stopped, preloaded directly, or reloaded from a holding value on command. When it wraps past its all-ones value it either reloads and keeps running or stops itself. An optional power-of-two prescaler slows the count rate. A compare stage flags the cycle in which the counter takes a programmed value. A capture stage latches the counter on chosen edges of an input pin, either on every edge or on every second edge into a second register. A waveform stage drives an output pin from overflow and compare events, as a one-cycle pulse or as a toggling level.

Three event flags (compare, wrap, capture) are held in a write-one-to-clear status register, and a single interrupt line is the OR of the flags that are enabled. Everything runs on one clock. The register port is a plain synchronous one: a write takes effect at the clock edge where `bus_wr` is high, and `bus_rdata` shows the addressed register combinationally. No data streams pass through the block, so there is no valid/ready handshake and no back-pressure. The port never stalls.

Top module: `gp_timer`

## Requirements
- R1: Register addresses are: 0 control, 1 counter, 2 reload value, 3 reload command, 4 compare value, 5 first capture, 6 second capture, 7 status, 8 interrupt enable. Address 3 and unused addresses read as zero. While reset is held, every register reads zero, `pwm_out` is low and `irq` is low.
- R2: When control bit 0 (run) is set, the counter advances by one at each count tick. Once a write clearing run has taken effect, the counter holds its value.
- R3: With control bit 5 clear, a count tick occurs on every clock while running. With bit 5 set, a tick occurs once every 2^(P+1) clocks, where P is control bits 4:2.
- R4: A tick at count 0xFFFFFFFF sets status bit 1. The counter then takes the reload value if control bit 1 is set. Otherwise it goes to zero and run is cleared.
- R5: Any write to address 3 copies the reload value into the counter whatever the data. A write to address 1 sets the counter. A counter write takes priority over a tick in the same cycle.
- R6: With control bit 6 set, a tick that moves the counter to the compare value sets status bit 0 at the same edge.
- R7: Control bits 9:8 choose the capture edges of `cap_in`: 01 rising, 10 falling, 11 both, 00 none. With control bit 13 clear, each chosen edge stores the counter into the first capture register and sets status bit 2.
- R8: With control bit 13 set, chosen edges alternate. The first edge stores into the first capture register. The second stores into the second capture register and sets status bit 2. Clearing bit 13 or bits 9:8 restarts the pair.
- R9: Writing 1 to a status bit clears it and writing 0 leaves it. An event in the same cycle as a clear leaves the bit set.
- R10: `irq` is high exactly when some status bit and its enable bit at address 8 (bits 2:0) are both set.
- R11: Control bits 11:10 choose the output trigger: 01 on wrap, 10 on wrap or compare, 00 and 11 none. With control bit 12 clear, the output shows the inverse of control bit 7 for the one cycle after a trigger and bit 7 otherwise.
- R12: With control bit 12 set, each trigger inverts the output. Any control write loads the output with the written bit 7.
- R13: With control bit 14 set, `pwm_out` shows control bit 7 regardless of triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| cap_in | input | 1 | Capture input, synchronous to clk |
| pwm_out | output | 1 | Waveform / level output |
| irq | output | 1 | Interrupt request |

## Verification
Several pairs of functions can land on the same edge. A hardware event can set a status flag in the cycle where software writes 1 to clear that same flag. A counter write can also coincide with a tick or a wrap. The bench provokes both by running a short reload loop, 16 counts long, and issuing clears and counter writes at every phase of that loop, so at least one falls exactly on a wrap or compare edge. A behavioural model is advanced on every clock, and the outputs and the addressed register are compared with it. A flag must survive its coincident clear, and the written counter value must beat the tick.

// File: rtl/gp_timer_pkg.sv
package gp_timer_pkg;

  localparam int PSC_W = 3;
  localparam int IRQ_N = 3;

  localparam int EV_MATCH = 0;
  localparam int EV_WRAP  = 1;
  localparam int EV_CAPT  = 2;

  typedef struct packed {
    logic             pin_static;
    logic             capt_pair;
    logic             out_toggle;
    logic [1:0]       out_trig;
    logic [1:0]       capt_edge;
    logic             idle_lvl;
    logic             cmp_en;
    logic             div_en;
    logic [PSC_W-1:0] div_sel;
    logic             reload_en;
    logic             run;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

  typedef enum logic [3:0] {
    RA_CTRL   = 4'd0,
    RA_COUNT  = 4'd1,
    RA_RELOAD = 4'd2,
    RA_KICK   = 4'd3,
    RA_CMP    = 4'd4,
    RA_CAPA   = 4'd5,
    RA_CAPB   = 4'd6,
    RA_STAT   = 4'd7,
    RA_IEN    = 4'd8
  } tmr_addr_e;

endpackage

// File: rtl/gp_timer_tick.sv
module gp_timer_tick
  import gp_timer_pkg::*;
#(
  parameter int PW = PSC_W
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          div_en,
  input  logic [PW-1:0] div_sel,
  output logic          tick
);
  localparam int DW = 1 << PW;

  logic [DW-1:0] div_q;
  logic [DW-1:0] div_lim;
  logic          div_end;

  always_comb div_lim = (DW'(1) << ({1'b0, div_sel} + (PW+1)'(1))) - DW'(1);
  assign div_end = (div_q == div_lim);
  assign tick    = run & (~div_en | div_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          div_q <= '0;
    else if (!run || !div_en || div_end) div_q <= '0;
    else                                 div_q <= div_q + DW'(1);
  end

  // R3: a divided tick is never followed by another tick at once
  assert_prescale_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_en) ##1 div_en |-> !tick);

endmodule

// File: rtl/gp_timer_core.sv
module gp_timer_core #(
  parameter int W = 32
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cmp_en,
  input  logic         reload_en,
  input  logic         wr_count,
  input  logic         wr_kick,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] reload_val,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] count,
  output logic         wrap_ev,
  output logic         match_ev
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;

  assign wrap_ev = tick & (&cnt_q);

  always_comb begin
    if (wrap_ev) cnt_nxt = reload_en ? reload_val : '0;
    else         cnt_nxt = cnt_q + W'(1);
  end

  assign match_ev = tick & cmp_en & (cnt_nxt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (wr_kick)  cnt_q <= reload_val;
    else if (wr_count) cnt_q <= wdata;
    else if (tick)     cnt_q <= cnt_nxt;
  end

  assign count = cnt_q;

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_count && !wr_kick) |=> $stable(cnt_q));

  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(&cnt_q) && !wr_count && !wr_kick) |=> (cnt_q == $past(cnt_q) + W'(1)));

  assert_kick_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_kick |=> (cnt_q == $past(reload_val)));

  assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&cnt_q) && !reload_en && !wr_count && !wr_kick) |=> (cnt_q == '0));

endmodule

// File: rtl/gp_timer_capture.sv
module gp_timer_capture #(
  parameter int W = 32
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_in,
  input  logic [1:0]   edge_sel,
  input  logic         pair_mode,
  input  logic [W-1:0] count,
  output logic [W-1:0] capt_a,
  output logic [W-1:0] capt_b,
  output logic         capt_ev
);
  logic         pin_d;
  logic         second_q;
  logic         hit;
  logic [W-1:0] capa_q, capb_q;

  assign hit = (edge_sel[0] & cap_in & ~pin_d) | (edge_sel[1] & ~cap_in & pin_d);
  assign capt_ev = hit & (~pair_mode | second_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_d    <= 1'b0;
      second_q <= 1'b0;
      capa_q   <= '0;
      capb_q   <= '0;
    end else begin
      pin_d <= cap_in;
      if (edge_sel == 2'b00 || !pair_mode) second_q <= 1'b0;
      else if (hit)                        second_q <= ~second_q;
      if (hit && (!pair_mode || !second_q)) capa_q <= count;
      if (hit && pair_mode && second_q)     capb_q <= count;
    end
  end

  assign capt_a = capa_q;
  assign capt_b = capb_q;

  assert_single_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !pair_mode) |=> (capa_q == $past(count)));

  assert_pair_second_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (capt_ev && pair_mode) |=> (capb_q == $past(count)));

endmodule

// File: rtl/gp_timer_wave.sv
module gp_timer_wave (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic       wr_idle_lvl,
  input  logic       idle_lvl,
  input  logic       toggle_mode,
  input  logic [1:0] trig_sel,
  input  logic       pin_static,
  input  logic       wrap_ev,
  input  logic       match_ev,
  output logic       wave_out
);
  logic fire;
  logic lvl_q;

  always_comb begin
    unique case (trig_sel)
      2'b01:   fire = wrap_ev;
      2'b10:   fire = wrap_ev | match_ev;
      default: fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lvl_q <= 1'b0;
    else if (ctrl_wr)     lvl_q <= wr_idle_lvl;
    else if (toggle_mode) lvl_q <= lvl_q ^ fire;
    else                  lvl_q <= fire ? ~idle_lvl : idle_lvl;
  end

  assign wave_out = pin_static ? idle_lvl : lvl_q;

  assert_toggle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle_mode && !fire && !ctrl_wr) |=> $stable(lvl_q));

  assert_pulse_idles_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!toggle_mode && !fire && !ctrl_wr) |=> (lvl_q == $past(idle_lvl)));

endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gp_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              cap_in,
  output logic              pwm_out,
  output logic              irq
);
  tmr_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] reload_q, cmp_q;
  logic [IRQ_N-1:0] ien_q, stat_q, stat_clr, stat_set;
  logic [CNT_W-1:0] count, capt_a, capt_b;
  logic             tick, wrap_ev, match_ev, capt_ev;
  logic             wr_ctrl, wr_count, wr_reload, wr_kick, wr_cmp, wr_stat, wr_ien;

  assign wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(RA_CTRL));
  assign wr_count  = bus_wr && (bus_addr == ADDR_W'(RA_COUNT));
  assign wr_reload = bus_wr && (bus_addr == ADDR_W'(RA_RELOAD));
  assign wr_kick   = bus_wr && (bus_addr == ADDR_W'(RA_KICK));
  assign wr_cmp    = bus_wr && (bus_addr == ADDR_W'(RA_CMP));
  assign wr_stat   = bus_wr && (bus_addr == ADDR_W'(RA_STAT));
  assign wr_ien    = bus_wr && (bus_addr == ADDR_W'(RA_IEN));

  gp_timer_tick #(.PW(PSC_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .div_en  (ctrl_q.div_en),
    .div_sel (ctrl_q.div_sel),
    .tick    (tick)
  );

  gp_timer_core #(.W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cmp_en     (ctrl_q.cmp_en),
    .reload_en  (ctrl_q.reload_en),
    .wr_count   (wr_count),
    .wr_kick    (wr_kick),
    .wdata      (bus_wdata),
    .reload_val (reload_q),
    .cmp_val    (cmp_q),
    .count      (count),
    .wrap_ev    (wrap_ev),
    .match_ev   (match_ev)
  );

  gp_timer_capture #(.W(CNT_W)) u_capt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_in    (cap_in),
    .edge_sel  (ctrl_q.capt_edge),
    .pair_mode (ctrl_q.capt_pair),
    .count     (count),
    .capt_a    (capt_a),
    .capt_b    (capt_b),
    .capt_ev   (capt_ev)
  );

  gp_timer_wave u_wave (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_wr     (wr_ctrl),
    .wr_idle_lvl (bus_wdata[7]),
    .idle_lvl    (ctrl_q.idle_lvl),
    .toggle_mode (ctrl_q.out_toggle),
    .trig_sel    (ctrl_q.out_trig),
    .pin_static  (ctrl_q.pin_static),
    .wrap_ev     (wrap_ev),
    .match_ev    (match_ev),
    .wave_out    (pwm_out)
  );

  always_comb begin
    stat_set           = '0;
    stat_set[EV_MATCH] = match_ev;
    stat_set[EV_WRAP]  = wrap_ev;
    stat_set[EV_CAPT]  = capt_ev;
    stat_clr           = wr_stat ? bus_wdata[IRQ_N-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      cmp_q    <= '0;
      ien_q    <= '0;
      stat_q   <= '0;
    end else begin
      if (wr_ctrl)                          ctrl_q     <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
      else if (wrap_ev && !ctrl_q.reload_en) ctrl_q.run <= 1'b0;
      if (wr_reload) reload_q <= bus_wdata;
      if (wr_cmp)    cmp_q    <= bus_wdata;
      if (wr_ien)    ien_q    <= bus_wdata[IRQ_N-1:0];
      stat_q <= (stat_q & ~stat_clr) | stat_set;
    end
  end

  assign irq = |(stat_q & ien_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(RA_CTRL):   bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      ADDR_W'(RA_COUNT):  bus_rdata = count;
      ADDR_W'(RA_RELOAD): bus_rdata = reload_q;
      ADDR_W'(RA_CMP):    bus_rdata = cmp_q;
      ADDR_W'(RA_CAPA):   bus_rdata = capt_a;
      ADDR_W'(RA_CAPB):   bus_rdata = capt_b;
      ADDR_W'(RA_STAT):   bus_rdata = {{(CNT_W-IRQ_N){1'b0}}, stat_q};
      ADDR_W'(RA_IEN):    bus_rdata = {{(CNT_W-IRQ_N){1'b0}}, ien_q};
      default:            bus_rdata = '0;
    endcase
  end

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(stat_q & ~stat_clr)) == $past(stat_q & ~stat_clr)));

  assert_wrap_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> stat_q[EV_WRAP]);

  assert_oneshot_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev && !ctrl_q.reload_en && !wr_ctrl) |=> !ctrl_q.run);

  assert_quiet_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |-> !irq);

endmodule

// File: tb/sim_gp_timer.sv
module sim_gp_timer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        cap_in = 1'b0;
  logic        pwm_out, irq;

  int n_chk = 0;
  int n_fail = 0;

  gp_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .pwm_out(pwm_out), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference state
  logic [31:0] m_cnt, m_load, m_cmp, m_c1, m_c2, m_nx;
  logic [14:0] m_ctrl;
  logic [2:0]  m_stat, m_ien, m_clr;
  logic        m_pind, m_second, m_lvl;
  int          m_div, m_lim;
  logic        e_tk, e_ov, e_mt, e_hit, e_cap, e_fire;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_load = 0; m_cmp = 0; m_c1 = 0; m_c2 = 0; m_ctrl = 0;
      m_stat = 0; m_ien = 0; m_pind = 0; m_second = 0; m_lvl = 0; m_div = 0;
    end else begin
      m_lim = (1 << (int'(m_ctrl[4:2]) + 1)) - 1;
      e_tk  = m_ctrl[0] && (!m_ctrl[5] || m_div == m_lim);
      e_ov  = e_tk && (m_cnt == 32'hFFFF_FFFF);
      m_nx  = e_ov ? (m_ctrl[1] ? m_load : 32'd0) : m_cnt + 32'd1;
      e_mt  = e_tk && m_ctrl[6] && (m_nx == m_cmp);
      e_hit = (m_ctrl[8] && cap_in && !m_pind) || (m_ctrl[9] && !cap_in && m_pind);
      e_cap = e_hit && (!m_ctrl[13] || m_second);
      e_fire = (m_ctrl[11:10] == 2'b01 && e_ov) || (m_ctrl[11:10] == 2'b10 && (e_ov || e_mt));
      if (e_hit) begin
        if (!m_ctrl[13] || !m_second) m_c1 = m_cnt;
        else m_c2 = m_cnt;
      end
      if (m_ctrl[9:8] == 2'b00 || !m_ctrl[13]) m_second = 0;
      else if (e_hit) m_second = !m_second;
      m_pind = cap_in;
      m_div = (!m_ctrl[0] || !m_ctrl[5] || m_div == m_lim) ? 0 : m_div + 1;
      if (bus_wr && bus_addr == 4'd3)      m_cnt = m_load;
      else if (bus_wr && bus_addr == 4'd1) m_cnt = bus_wdata;
      else if (e_tk)                       m_cnt = m_nx;
      m_clr  = (bus_wr && bus_addr == 4'd7) ? bus_wdata[2:0] : 3'd0;
      m_stat = (m_stat & ~m_clr) | {e_cap, e_ov, e_mt};
      if (bus_wr && bus_addr == 4'd0) m_lvl = bus_wdata[7];
      else if (m_ctrl[12])            m_lvl = m_lvl ^ e_fire;
      else                            m_lvl = e_fire ? !m_ctrl[7] : m_ctrl[7];
      if (bus_wr && bus_addr == 4'd0) m_ctrl = bus_wdata[14:0];
      else if (e_ov && !m_ctrl[1])    m_ctrl[0] = 1'b0;
      if (bus_wr && bus_addr == 4'd2) m_load = bus_wdata;
      if (bus_wr && bus_addr == 4'd4) m_cmp  = bus_wdata;
      if (bus_wr && bus_addr == 4'd8) m_ien  = bus_wdata[2:0];
    end
  end

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return {17'd0, m_ctrl};
      4'd1: return m_cnt;
      4'd2: return m_load;
      4'd4: return m_cmp;
      4'd5: return m_c1;
      4'd6: return m_c2;
      4'd7: return {29'd0, m_stat};
      4'd8: return {29'd0, m_ien};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string addr_tag(input logic [3:0] a);
    case (a)
      4'd1: return (m_ctrl[5] ? "R3" : "R2");
      4'd2, 4'd3: return "R5";
      4'd4: return "R6";
      4'd5: return "R7";
      4'd6: return "R8";
      4'd7: return "R9";
      4'd8: return "R10";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(addr_tag(bus_addr), bus_rdata, m_read(bus_addr));
      chk("R10", {31'd0, irq}, {31'd0, |(m_stat & m_ien)});
      chk(m_ctrl[14] ? "R13" : (m_ctrl[12] ? "R12" : "R11"),
          {31'd0, pwm_out}, {31'd0, (m_ctrl[14] ? m_ctrl[7] : m_lvl)});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic watch(input logic [3:0] a, input int n);
    bus_addr = a;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pin(input logic v, input int n);
    @(posedge clk); #1;
    cap_in = v;
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  logic [31:0] held;

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    for (int a = 0; a < 16; a++) begin
      bus_addr = 4'(a);
      #1;
      chk("R1", bus_rdata, 32'd0);
    end
    chk("R1", {30'd0, pwm_out, irq}, 32'd0);
    rst_n = 1'b1;

    // R2: counting and stopping
    wr(4'd8, 32'd7);
    wr(4'd1, 32'd100);
    wr(4'd0, 32'h1);
    watch(4'd1, 10);
    chk("R2", bus_rdata, 32'd110);
    wr(4'd0, 32'h0);
    watch(4'd1, 3);
    held = bus_rdata;
    watch(4'd1, 6);
    chk("R2", bus_rdata, held);

    // R4 R6 R11: reload loop with compare and pulse output
    wr(4'd4, 32'hFFFF_FFF8);
    wr(4'd2, 32'hFFFF_FFF0);
    wr(4'd1, 32'hFFFF_FFF0);
    wr(4'd0, 32'h1 | 32'h2 | 32'h40 | (32'h2 << 10));
    watch(4'd7, 40);
    // R9: clears and counter writes at every loop phase
    for (int k = 0; k < 18; k++) begin
      wr(4'd7, 32'h3);
      watch(4'd7, 1);
    end
    for (int k = 0; k < 9; k++) begin
      wr(4'd1, 32'hFFFF_FFF6);
      watch(4'd1, k);
    end

    // R4: one-shot wrap stops the counter
    wr(4'd0, 32'h0);
    wr(4'd1, 32'hFFFF_FFFC);
    wr(4'd0, 32'h1);
    watch(4'd1, 10);
    chk("R4", bus_rdata, 32'd0);
    watch(4'd0, 1);
    chk("R4", bus_rdata & 32'h1, 32'd0);

    // R5: reload command ignores its data
    wr(4'd2, 32'h1234);
    wr(4'd3, 32'hDEAD_BEEF);
    watch(4'd1, 1);
    chk("R5", bus_rdata, 32'h1234);
    wr(4'd1, 32'd77);
    watch(4'd1, 1);
    chk("R5", bus_rdata, 32'd77);

    // R3: prescaler divide by 4, then by 2
    wr(4'd1, 32'd0);
    wr(4'd0, 32'h1 | 32'h20 | (32'h1 << 2));
    watch(4'd1, 8);
    chk("R3", bus_rdata, 32'd2);
    wr(4'd0, 32'h1 | 32'h20);
    watch(4'd1, 20);
    wr(4'd0, 32'h0);

    // R7: capture edges, single mode
    wr(4'd1, 32'd0);
    wr(4'd0, 32'h1 | (32'h1 << 8));
    pin(1'b1, 3); pin(1'b0, 3);
    watch(4'd5, 2);
    wr(4'd7, 32'h4);
    wr(4'd0, 32'h1 | (32'h2 << 8));
    pin(1'b1, 4); pin(1'b0, 2);
    watch(4'd5, 2);
    wr(4'd0, 32'h1 | (32'h3 << 8));
    pin(1'b1, 3); pin(1'b0, 5);
    watch(4'd7, 2);
    // R8: paired capture
    wr(4'd0, 32'h1 | (32'h1 << 8) | (32'h1 << 13));
    pin(1'b1, 2); pin(1'b0, 2); pin(1'b1, 3); pin(1'b0, 1);
    watch(4'd6, 2);
    pin(1'b1, 2); pin(1'b0, 2);
    watch(4'd5, 2);
    wr(4'd0, 32'h1 | (32'h3 << 8) | (32'h1 << 13));
    pin(1'b1, 2); pin(1'b0, 3);
    watch(4'd6, 2);

    // R12: toggle output on wrap, then on wrap or compare
    wr(4'd2, 32'hFFFF_FFFA);
    wr(4'd1, 32'hFFFF_FFFA);
    wr(4'd0, 32'h1 | 32'h2 | (32'h1 << 12) | (32'h1 << 10) | 32'h80);
    watch(4'd1, 30);
    wr(4'd4, 32'hFFFF_FFFC);
    wr(4'd0, 32'h1 | 32'h2 | 32'h40 | (32'h1 << 12) | (32'h2 << 10));
    watch(4'd7, 30);

    // R13: static pin level
    wr(4'd0, 32'h1 | 32'h2 | (32'h1 << 12) | (32'h1 << 10) | 32'h80 | (32'h1 << 14));
    watch(4'd1, 20);
    chk("R13", {31'd0, pwm_out}, 32'd1);
    wr(4'd8, 32'h0);
    watch(4'd8, 2);
    chk("R10", {31'd0, irq}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule